// File: doc/BRIEF.md
# Programmable Scan Clock Generator with Period Counters

This block turns the master clock into the boundary-scan test clock, with a divide ratio supplied each time a test is loaded. A ratio of N gives a test clock with a period of 2×(N+1) master clocks and a 50% duty cycle, so N = 0 is the fastest rate. The test clock starts on the first load after reset and stays low until then. Each rising and falling transition comes with a one-master-clock tick pulse. A separate shift engine uses these ticks to change its outputs on the falling edge and to sample on the rising edge.

Each load also arms a 16-bit start-delay counter. This counter measures settling time in whole test-clock periods and raises a start flag when the board may be driven. Once the start flag is up, an idle request arms a second 16-bit counter that measures a run-test-idle stretch in test-clock periods. A ratio loaded while the clock runs is held back until the end of the period in progress, so the clock never shows a short pulse.

Top module: `tck_pacer`

## Requirements
- R1: While reset is asserted (rst_n = 0) and in the first cycle after it, tck, tck_rise, tck_fall, start_done and idle_done are all 0.
- R2: Before the first cfg_load after reset, tck stays 0 and neither tick pulses.
- R3: A cfg_load sampled at clock edge k with cfg_div = N on a stopped clock starts the clock. tck is high after edge k+t exactly when floor(t/(N+1)) is odd. Each half period is N+1 master clocks, so the first rise follows edge k+N+1.
- R4: tck_rise is 1 for exactly the one cycle in which tck has just become 1. tck_fall is 1 for exactly the one cycle in which tck has just become 0. The two are never 1 together.
- R5: cfg_delay = D arms the start counter. start_done becomes 1 with the (D+1)-th tck rise after the load edge, so D = 0 raises it on the first rise. start_done then holds until the next load. A rise at the load edge itself is not counted.
- R6: A cfg_load while the clock runs keeps the old ratio until the next tck fall. The periods after that fall use the new ratio, starting with a low half of N_new+1 clocks.
- R7: An idle_req with idle_cnt = C, sampled while start_done = 1, clears idle_done. idle_done becomes 1 with the (C+1)-th tck rise after that edge and holds until the next load or accepted request. A rise at the request edge is not counted.
- R8: An idle_req sampled while start_done = 0 is ignored, and idle_done stays 0.
- R9: The cycle after a cfg_load, both start_done and idle_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for ratio and start delay |
| cfg_div | input | DIV_W | Divide ratio N; half period is N+1 clocks |
| cfg_delay | input | CNT_W | Start delay in test-clock periods |
| idle_req | input | 1 | Run-test-idle count request strobe |
| idle_cnt | input | CNT_W | Idle length in test-clock periods |
| tck | output | 1 | Generated test clock |
| tck_rise | output | 1 | One-cycle tick on each tck rise |
| tck_fall | output | 1 | One-cycle tick on each tck fall |
| start_done | output | 1 | Start delay elapsed |
| idle_done | output | 1 | Idle count elapsed |

## Verification
The bench builds the block with a 3-bit ratio field and the 16-bit counters, with the idle counter generated. This makes every divide ratio from 0 to 7 reachable in a short run. Each ratio is swept against start delays 0 to 3, and the waveform, both tick streams and the start flag are predicted per cycle from the period formula. Directed runs reload a ratio mid-period, sweep idle counts 0 to 3, and issue an idle request before the start flag. Together these reach the boundary-held reload and the rule that a request is ignored.

// File: rtl/tckp_pkg.sv
package tckp_pkg;
   // Width of the period counters used for start delay and idle stretches
   localparam int unsigned PERIOD_CNT_W = 16;

   // Divider phase: stopped (never loaded), low half, high half
   typedef enum logic [1:0] {
      PH_STOP = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } tck_phase_e;
endpackage

// File: rtl/tckp_divider.sv
module tckp_divider
   import tckp_pkg::*;
#(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   output logic             tck,
   output logic             tick_rise,
   output logic             tick_fall,
   output logic             rise_evt
);
   tck_phase_e       phase;
   logic [DIV_W-1:0] ph_cnt;
   logic [DIV_W-1:0] cur_div;
   logic [DIV_W-1:0] pend_div;
   logic             half_end;

   assign half_end = (phase != PH_STOP) && (ph_cnt == cur_div);
   assign rise_evt = half_end && (phase == PH_LOW);
   assign tck      = (phase == PH_HIGH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_STOP;
         ph_cnt    <= '0;
         cur_div   <= '0;
         pend_div  <= '0;
         tick_rise <= 1'b0;
         tick_fall <= 1'b0;
      end else begin
         tick_rise <= 1'b0;
         tick_fall <= 1'b0;
         if (load) begin
            pend_div <= div_in;
         end
         if (phase == PH_STOP) begin
            if (load) begin
               phase   <= PH_LOW;
               cur_div <= div_in;
               ph_cnt  <= '0;
            end
         end else if (half_end) begin
            ph_cnt <= '0;
            if (phase == PH_LOW) begin
               phase     <= PH_HIGH;
               tick_rise <= 1'b1;
            end else begin
               phase     <= PH_LOW;
               tick_fall <= 1'b1;
               // period boundary: take the newest ratio
               cur_div   <= load ? div_in : pend_div;
            end
         end else begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tckp_period_count.sv
module tckp_period_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             arm,
   input  logic [CNT_W-1:0] arm_val,
   input  logic             rise_evt,
   output logic             done
);
   logic [CNT_W-1:0] remaining;
   logic             armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
         armed     <= 1'b0;
         done      <= 1'b0;
      end else if (clr) begin
         armed <= 1'b0;
         done  <= 1'b0;
      end else if (arm) begin
         remaining <= arm_val;
         armed     <= 1'b1;
         done      <= 1'b0;
      end else if (armed && rise_evt) begin
         if (remaining == '0) begin
            armed <= 1'b0;
            done  <= 1'b1;
         end else begin
            remaining <= remaining - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tck_pacer.sv
module tck_pacer
   import tckp_pkg::*;
#(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned CNT_W   = PERIOD_CNT_W,
   parameter bit          IDLE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic             idle_req,
   input  logic [CNT_W-1:0] idle_cnt,
   output logic             tck,
   output logic             tck_rise,
   output logic             tck_fall,
   output logic             start_done,
   output logic             idle_done
);
   logic rise_evt;

   if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div_w
      $error("tck_pacer: DIV_W must be 1..24");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("tck_pacer: CNT_W must be 1..32");
   end

   tckp_divider #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .div_in    (cfg_div),
      .tck       (tck),
      .tick_rise (tck_rise),
      .tick_fall (tck_fall),
      .rise_evt  (rise_evt)
   );

   tckp_period_count #(.CNT_W(CNT_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (1'b0),
      .arm      (cfg_load),
      .arm_val  (cfg_delay),
      .rise_evt (rise_evt),
      .done     (start_done)
   );

   if (IDLE_EN) begin : g_idle
      logic idle_arm;
      assign idle_arm = idle_req && start_done;
      tckp_period_count #(.CNT_W(CNT_W)) u_idle (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (cfg_load),
         .arm      (idle_arm),
         .arm_val  (idle_cnt),
         .rise_evt (rise_evt),
         .done     (idle_done)
      );
   end else begin : g_no_idle
      assign idle_done = 1'b0;
   end
endmodule

// File: rtl/tck_pacer_chk.sv
module tck_pacer_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_load,
   input logic idle_req,
   input logic tck,
   input logic tck_rise,
   input logic tck_fall,
   input logic start_done,
   input logic idle_done
);
   logic seen_load;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_load <= 1'b0;
      else if (cfg_load) seen_load <= 1'b1;
   end

   // R2
   stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_load |-> (!tck && !tck_rise && !tck_fall));

   // R4
   rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tck_rise |-> (tck && !$past(tck)));

   // R4
   fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tck_fall |-> (!tck && $past(tck)));

   // R4
   tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tck_rise, tck_fall}));

   // R4
   edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck) |-> tck_rise);

   // R5
   start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_done) |-> tck_rise);

   // R7
   idle_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_done) |-> tck_rise);

   // R8
   idle_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_req && !start_done && !idle_done) |=> !idle_done);

   // R9
   load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (!start_done && !idle_done));
endmodule

bind tck_pacer tck_pacer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_load   (cfg_load),
   .idle_req   (idle_req),
   .tck        (tck),
   .tck_rise   (tck_rise),
   .tck_fall   (tck_fall),
   .start_done (start_done),
   .idle_done  (idle_done)
);

// File: tb/tck_pacer_test.sv
module tck_pacer_test;
   localparam int CLK_P = 10;
   localparam int DW    = 3;
   localparam int CW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic [DW-1:0] cfg_div = '0;
   logic [CW-1:0] cfg_delay = '0;
   logic          idle_req = 1'b0;
   logic [CW-1:0] idle_cnt = '0;
   logic          tck, tck_rise, tck_fall, start_done, idle_done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tck_pacer #(.DIV_W(DW), .CNT_W(CW), .IDLE_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
      .cfg_delay(cfg_delay), .idle_req(idle_req), .idle_cnt(idle_cnt),
      .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall),
      .start_done(start_done), .idle_done(idle_done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_load = 1'b0; idle_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R1: outputs idle during reset
      chk({tck, tck_rise, tck_fall, start_done, idle_done} == 5'b0, "R1",
          {tck, tck_rise, tck_fall, start_done, idle_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tck, tck_rise, tck_fall, start_done, idle_done} == 5'b0, "R1",
          {tck, tck_rise, tck_fall, start_done, idle_done}, 0);
   endtask

   function automatic int exp_tck(int t, int n);
      return ((t / (n + 1)) % 2 == 1) ? 1 : 0;
   endfunction

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog act=1 exp=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R2: no clock before first load
      do_reset();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(!tck && !tck_rise && !tck_fall, "R2", {tck, tck_rise, tck_fall}, 0);
      end

      // R3 R4 R5: sweep ratio and start delay
      for (int n = 0; n < 8; n++) begin
         for (int d = 0; d < 4; d++) begin
            do_reset();
            cfg_div = DW'(n); cfg_delay = CW'(d); cfg_load = 1'b1;
            for (int t = 0; t <= (2*d + 3) * (n + 1); t++) begin
               @(negedge clk);
               if (t == 0) cfg_load = 1'b0;
               chk(int'(tck) == exp_tck(t, n), "R3", tck, exp_tck(t, n));
               chk(int'(tck_rise) == ((t > 0 && t % (n+1) == 0 && exp_tck(t, n) == 1) ? 1 : 0),
                   "R4 rise", tck_rise, (t > 0 && t % (n+1) == 0 && exp_tck(t, n) == 1) ? 1 : 0);
               chk(int'(tck_fall) == ((t > 0 && t % (n+1) == 0 && exp_tck(t, n) == 0) ? 1 : 0),
                   "R4 fall", tck_fall, (t > 0 && t % (n+1) == 0 && exp_tck(t, n) == 0) ? 1 : 0);
               chk(int'(start_done) == ((t >= (2*d + 1) * (n + 1)) ? 1 : 0), "R5",
                   start_done, (t >= (2*d + 1) * (n + 1)) ? 1 : 0);
            end
         end
      end

      // R6 R9: reload ratio 1 -> 3 during the high half
      do_reset();
      cfg_div = 3'd1; cfg_delay = '0; cfg_load = 1'b1;
      for (int t = 0; t <= 18; t++) begin
         int et;
         int ed;
         @(negedge clk);
         if (t == 0) cfg_load = 1'b0;
         if (t == 3) cfg_load = 1'b0;
         et = (t <= 4) ? exp_tck(t, 1) : exp_tck(t - 4, 3);
         ed = (t == 2) ? 1 : ((t >= 8) ? 1 : 0);
         chk(int'(tck) == et, "R6", tck, et);
         if (t >= 2) chk(int'(start_done) == ed, (t >= 3 && t < 8) ? "R9" : "R5", start_done, ed);
         if (t == 2) begin cfg_div = 3'd3; cfg_load = 1'b1; end
      end

      // R7 R9: idle count sweep at fastest rate (rises at odd t)
      for (int c = 0; c < 4; c++) begin
         do_reset();
         cfg_div = '0; cfg_delay = '0; cfg_load = 1'b1;
         for (int t = 0; t <= 8 + 2*c; t++) begin
            int ei;
            @(negedge clk);
            if (t == 0) cfg_load = 1'b0;
            if (t == 3) idle_req = 1'b0;
            ei = (t >= 5 + 2*c) ? 1 : 0;
            chk(int'(idle_done) == ei, "R7", idle_done, ei);
            if (t == 2) begin idle_cnt = CW'(c); idle_req = 1'b1; end
         end
         cfg_load = 1'b1;
         @(negedge clk);
         cfg_load = 1'b0;
         chk(!start_done && !idle_done, "R9", {start_done, idle_done}, 0);
      end

      // R8: request before start flag is ignored
      do_reset();
      cfg_div = '0; cfg_delay = CW'(3); cfg_load = 1'b1;
      for (int t = 0; t <= 20; t++) begin
         @(negedge clk);
         if (t == 0) cfg_load = 1'b0;
         if (t == 2) idle_req = 1'b0;
         chk(!idle_done, "R8", idle_done, 0);
         if (t == 1) begin idle_cnt = '0; idle_req = 1'b1; end
      end
      chk(start_done, "R5", start_done, 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule